// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block turns one PWM level from a timer into a pair of complementary outputs, a true output and an inverted output. The two outputs are never high at the same time. When the PWM input changes level, the output that is switching off drops at the next clock. The output that is switching on stays low for a programmable dead time and rises only after that time has elapsed. This gap keeps an external high-side and low-side switch pair from conducting together.

Each output has its own 4-bit dead-time value. The true output uses its value after a rising PWM edge, and the inverted output uses its value after a falling edge. A 4-bit down-counter measures the dead time. That counter advances on a prescaled tick, which divides the clock by 1, 2, 4 or 8.

A single configuration word holds both dead-time values and the prescaler select. The block samples that word at the start of each dead-time period, so rewriting it never disturbs a count that is already running.

Top module: `pwm_deadband`

## Requirements
- R1: While the synchronous reset `rst` is high, both outputs are low at every clock edge. Reset also clears the internal counter, the prescaler divider, the stored PWM level and the configuration word.
- R2: A clock edge with `cfg_we` high stores `cfg_wdata`. Bits [3:0] hold the true-output delay D_hi, bits [7:4] hold the inverted-output delay D_lo, and bits [9:8] hold the prescaler select. The select encodings give divisor N = 1 for 00, 2 for 01, 4 for 10 and 8 for 11.
- R3: Call edge E the first clock edge that samples a changed `pwm_in`. After edge E, both outputs are low, so the output that is switching off falls at E.
- R4: After a rising PWM change, `out_true` is low up to and including edge E + D_hi*N, and it is high from edge E + D_hi*N + 1 onward. `out_comp` stays low throughout.
- R5: After a falling PWM change, `out_comp` is low up to and including edge E + D_lo*N, and it is high from edge E + D_lo*N + 1 onward. `out_true` stays low throughout.
- R6: With a delay value of 0, the output switching on rises at edge E + 1, whatever the prescaler select.
- R7: `out_true` and `out_comp` are never high after the same clock edge.
- R8: If `pwm_in` changes again before the pending output has risen, that pending turn-on is cancelled. The counter reloads with the delay for the new direction, and timing restarts from the new edge as in R4 and R5.
- R9: A configuration write made while a dead time is counting has no effect on that count. The new values take effect at the next PWM edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_in | input | 1 | PWM level from the timer |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 10 | Configuration word: {select[1:0], D_lo[3:0], D_hi[3:0]} |
| out_true | output | 1 | Non-inverted output with dead time |
| out_comp | output | 1 | Inverted output with dead time |

## Verification
Every result is counted from edge E, the first clock edge that sees the new PWM level. The output switching off must read low right after E. The output switching on must read low through edge E + D*N and high from edge E + D*N + 1. The bench drives inputs and samples outputs on falling clock edges. It checks both outputs after every rising edge over the whole window, and it sweeps all 16 delay values under all 4 prescaler selects. This pins down the exact rising edge rather than some edge in a range. Retrigger and mid-count rewrite cases are timed from the second edge or from the original configuration.

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DT_W = 4,
  parameter int PS_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pwm_in,
  input  logic                     cfg_we,
  input  logic [2*DT_W+PS_W-1:0]   cfg_wdata,
  output logic                     out_true,
  output logic                     out_comp
);
  localparam int CFG_W = 2*DT_W + PS_W;
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [CFG_W-1:0] cfg_q;
  logic             pwm_q;
  logic [DT_W-1:0]  cnt;
  logic [PS_W-1:0]  psel_act;
  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] mask;

  wire [DT_W-1:0] dt_hi    = cfg_q[DT_W-1:0];
  wire [DT_W-1:0] dt_lo    = cfg_q[2*DT_W-1:DT_W];
  wire [PS_W-1:0] psel_cfg = cfg_q[CFG_W-1 -: PS_W];
  wire            edge_det = pwm_in ^ pwm_q;
  wire            cnt_zero = (cnt == '0);
  wire            tick     = ((div & mask) == mask);

  always_comb begin
    for (int i = 0; i < DIV_W; i++)
      mask[i] = (i < int'(psel_act));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      pwm_q    <= 1'b0;
      cnt      <= '0;
      psel_act <= '0;
      div      <= '0;
      out_true <= 1'b0;
      out_comp <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      pwm_q <= pwm_in;
      if (edge_det) begin
        cnt      <= pwm_in ? dt_hi : dt_lo;
        psel_act <= psel_cfg;
        div      <= '0;
        out_true <= 1'b0;
        out_comp <= 1'b0;
      end else begin
        div <= div + 1'b1;
        if (tick && !cnt_zero) cnt <= cnt - 1'b1;
        out_true <=  pwm_q & cnt_zero;
        out_comp <= !pwm_q & cnt_zero;
      end
    end
  end

  // R1
  reset_low_chk: assert property (@(posedge clk)
    rst |=> (!out_true && !out_comp));

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_true && out_comp));

  // R3
  turn_off_chk: assert property (@(posedge clk) disable iff (rst)
    edge_det |=> (!out_true && !out_comp));

  // R4
  dead_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_zero |-> (!out_true && !out_comp));

  // R9
  psel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !edge_det |=> $stable(psel_act));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !edge_det |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));
endmodule

// File: tb/tb_pwm_deadband.sv
`timescale 1ns/1ps
module tb_pwm_deadband;
  logic       clk = 1'b0;
  logic       rst;
  logic       pwm_in;
  logic       cfg_we;
  logic [9:0] cfg_wdata;
  logic       out_true, out_comp;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pwm_deadband dut (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .out_true(out_true), .out_comp(out_comp)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic write_cfg(input int p, input int lo, input int hi);
    cfg_we    = 1'b1;
    cfg_wdata = {2'(p), 4'(lo), 4'(hi)};
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // Drive a new PWM level and check both outputs after each edge E+k.
  task automatic run_edge(input logic lvl, input int d, input int n, input string tag);
    pwm_in = lvl;
    for (int k = 0; k <= d*n + 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(tag, lvl ? "out_true" : "out_comp", lvl ? out_true : out_comp, k >= d*n + 1);
      chk("R3", lvl ? "out_comp" : "out_true", lvl ? out_comp : out_true, 1'b0);
      chk("R7", "overlap", out_true & out_comp, 1'b0);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #900000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; pwm_in = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1", "out_true in reset", out_true, 1'b0);
    chk("R1", "out_comp in reset", out_comp, 1'b0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "out_comp settles after reset", out_comp, 1'b1);

    // R2 R4 R5 R6: full sweep of select and delay values
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d < 16; d++) begin
        write_cfg(p, d, 15 - d);
        run_edge(1'b1, 15 - d, 1 << p, (15 - d == 0) ? "R6" : "R4");
        run_edge(1'b0, d, 1 << p, (d == 0) ? "R6" : "R5");
      end
    end

    // R8: retrigger before expiry cancels the pending rise
    write_cfg(1, 3, 5);
    pwm_in = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R8", "out_true before retrigger", out_true, 1'b0);
      chk("R8", "out_comp before retrigger", out_comp, 1'b0);
    end
    run_edge(1'b0, 3, 2, "R8");

    // R9: rewrite in mid-count keeps the original timing
    write_cfg(2, 0, 3);
    pwm_in = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = {2'd0, 4'd0, 4'd0};
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    for (int k = 3; k <= 16; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R9", "out_true after mid-count write", out_true, k >= 13);
    end
    // R9: new word applies at the next edge (delay 0, divisor 1)
    run_edge(1'b0, 0, 1, "R9");

    finish_run();
  end
endmodule